// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host memory by walking a linked chain of four-word descriptors: status, control, buffer address and next pointer. A host command starts the walk. The engine reads one descriptor and confirms that it owns it. It then accepts one frame from a byte stream and writes the bytes into the buffer that the descriptor names. When the frame is complete, it writes a status word that holds the length, error and class flags, and that status word hands ownership back to the host.

Each descriptor is read as four consecutive words at offsets +0, +4, +8 and +12. When a frame has been written back, the engine follows the next pointer on its own. A null next pointer stops it and clears its position, so the next poll starts again at the ring base. A descriptor that the engine does not own also stops it. In that case it raises a no-buffer strobe and keeps its position, so a poll retries the same descriptor. Each good frame produces a receive-done strobe.

The memory port is a plain word port with byte enables. Read data returns one cycle after a read request, and writes take effect on the clock edge.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset, rx_ready, mem_rd, mem_wr, rx_done and no_buf are all low. A poll while the engine is idle and its pointer is null starts a fetch at ring_base. The first read is issued in the cycle after poll is sampled.
- R2: A descriptor is used only when status bit 31 is 1. If bit 31 is 0, no_buf pulses for exactly one cycle and no byte is accepted. The engine then stays idle until a poll, which re-reads that same descriptor.
- R3: The buffer size is control bits [10:0]. Frame byte n is written to byte address buffer+n, with lane n mod 4 enabled. No write is issued with all byte enables low.
- R4: Bytes at offset buffer size or beyond are never written. Such a truncated frame sets status bit 7.
- R5: The status write clears bit 31 and sets bits 9 and 8. Bits [26:16] hold the number of bytes received, CRC included.
- R6: Status bits 1, 2, 3 and 6 copy the CRC, alignment, FIFO-overflow and system-error inputs sampled with the last byte. Bit 5 marks a length below MIN_FRAME, and bit 4 marks a length above MAX_FRAME.
- R7: Status bit 0 is the OR of bits 7, 6, 3, 2 and 1, and bit 15 is its inverse.
- R8: rx_kind sets the class bits: 1 sets bit 11 (address match), 2 sets bit 12 (broadcast), 3 sets bit 13 (multicast), and 0 sets none of them.
- R9: The status word of a frame is written only after every buffer write of that frame.
- R10: rx_done is high for one cycle, in the cycle after the status write of a frame with bit 15 set, and at no other time.
- R11: After writeback, a non-zero next pointer makes the engine fetch that descriptor without a poll. A zero next pointer stops the engine, and the next poll starts at ring_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll | input | 1 | Poll demand: start or restart the descriptor fetch |
| ring_base | input | AW | First descriptor address, used when the pointer is null |
| rx_valid | input | 1 | Byte-stream data valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_crc_bad | input | 1 | CRC error, sampled with the last byte |
| rx_align_bad | input | 1 | Alignment error, sampled with the last byte |
| rx_fifo_ovf | input | 1 | FIFO overflow, sampled with the last byte |
| rx_sys_err | input | 1 | System error, sampled with the last byte |
| rx_kind | input | 2 | Destination class: 0 none, 1 match, 2 broadcast, 3 multicast |
| rx_ready | output | 1 | Engine is accepting bytes |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for the write |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| rx_done | output | 1 | Good-frame receive strobe |
| no_buf | output | 1 | No-owned-descriptor strobe |

## Verification
The bench builds the engine with MIN_FRAME=64 and MAX_FRAME=100. With these values a 120-byte frame sets the long bit and a 30-byte frame sets the runt bit, so both length checks are reached with short runs. One descriptor declares a 40-byte buffer so that truncation and the untouched sentinel byte past the buffer can be observed. A second chain leaves its last descriptor unowned, which brings both the no-buffer stop and the poll-driven retry of that same descriptor within reach.

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine #(
  parameter int AW        = 32,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_bad,
  input  logic          rx_align_bad,
  input  logic          rx_fifo_ovf,
  input  logic          rx_sys_err,
  input  logic [1:0]    rx_kind,
  output logic          rx_ready,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  output logic          rx_done,
  output logic          no_buf
);

  localparam int LW = 11;
  localparam logic [LW-1:0] LEN_TOP = '1;

  typedef enum logic [2:0] {S_IDLE, S_RS, S_RC, S_RB, S_RN, S_RL, S_RX, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] ptr, bufa, nxt, wr_addr;
  logic [LW-1:0] bsz, cnt, flen;
  logic [31:0]   pack, wr_data;
  logic [3:0]    pbe, wr_be;
  logic [3:0]    errs;
  logic [1:0]    kind;
  logic          wr_pend;

  logic [1:0]    lane;
  logic [31:0]   pack_n;
  logic [3:0]    be_n;
  logic [LW-1:0] cnt_n;
  logic          flush;

  assign lane  = cnt[1:0];
  assign cnt_n = (cnt == LEN_TOP) ? cnt : cnt + 1'b1;
  assign flush = (lane == 2'd3) || rx_last;

  always_comb begin
    pack_n = pack;
    pack_n[8*lane +: 8] = rx_data;
    be_n = pbe | (4'((cnt < bsz) ? 1 : 0) << lane);
  end

  logic       trunc, is_long, is_runt, sum;
  logic [31:0] sts;
  assign trunc   = flen > bsz;
  assign is_long = int'(flen) > MAX_FRAME;
  assign is_runt = int'(flen) < MIN_FRAME;
  assign sum     = trunc | errs[3] | errs[2] | errs[1] | errs[0];
  assign sts = {1'b0, 4'b0, flen, ~sum, 1'b0,
                kind == 2'd3, kind == 2'd2, kind == 2'd1, 1'b0, 2'b11,
                trunc, errs[3], is_runt, is_long, errs[2], errs[1], errs[0], sum};

  assign rx_ready = (st == S_RX);

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    mem_be    = '0;
    if (wr_pend) begin
      mem_wr    = 1'b1;
      mem_addr  = wr_addr;
      mem_wdata = wr_data;
      mem_be    = wr_be;
    end else begin
      case (st)
        S_RS: mem_rd = 1'b1;
        S_RC: begin mem_rd = 1'b1; mem_addr = ptr + AW'(4);  end
        S_RB: begin mem_rd = 1'b1; mem_addr = ptr + AW'(8);  end
        S_RN: begin mem_rd = 1'b1; mem_addr = ptr + AW'(12); end
        S_WB: begin mem_wr = 1'b1; mem_wdata = sts; mem_be = 4'hf; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; bufa <= '0; nxt <= '0; bsz <= '0; cnt <= '0;
      flen <= '0; pack <= '0; pbe <= '0; errs <= '0; kind <= '0;
      wr_pend <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_be <= '0;
      rx_done <= 1'b0; no_buf <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      no_buf  <= 1'b0;
      wr_pend <= 1'b0;
      case (st)
        S_IDLE: if (poll) begin
          if (ptr == '0) ptr <= ring_base;
          st <= S_RS;
        end
        S_RS: st <= S_RC;
        S_RC: if (!mem_rdata[31]) begin
          no_buf <= 1'b1;
          st     <= S_IDLE;
        end else st <= S_RB;
        S_RB: begin bsz <= mem_rdata[LW-1:0]; st <= S_RN; end
        S_RN: begin bufa <= mem_rdata[AW-1:0]; st <= S_RL; end
        S_RL: begin
          nxt  <= mem_rdata[AW-1:0];
          cnt  <= '0;
          pack <= '0;
          pbe  <= '0;
          st   <= S_RX;
        end
        S_RX: if (rx_valid) begin
          cnt  <= cnt_n;
          pack <= pack_n;
          pbe  <= be_n;
          if (flush) begin
            wr_pend <= |be_n;
            wr_addr <= bufa + AW'({cnt[LW-1:2], 2'b00});
            wr_data <= pack_n;
            wr_be   <= be_n;
            pack    <= '0;
            pbe     <= '0;
          end
          if (rx_last) begin
            flen <= cnt_n;
            errs <= {rx_sys_err, rx_fifo_ovf, rx_align_bad, rx_crc_bad};
            kind <= rx_kind;
            st   <= S_WB;
          end
        end
        S_WB: if (!wr_pend) begin
          rx_done <= ~sum;
          if (nxt == '0) begin
            ptr <= '0;
            st  <= S_IDLE;
          end else begin
            ptr <= nxt;
            st  <= S_RS;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxd_ring_engine_chk.sv
module rxd_ring_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        rx_done,
  input logic        no_buf
);

  // R3
  no_empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_be != 4'h0);

  // R2
  nobuf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |=> !no_buf);

  // R10
  done_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(mem_wr && !mem_wdata[31] && mem_wdata[15] && mem_be == 4'hf));

  // R10
  done_nobuf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !no_buf);

  // R9
  no_fetch_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_rd);

  // R3
  one_port_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind rxd_ring_engine rxd_ring_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .rx_done(rx_done), .no_buf(no_buf)
);

// File: tb/rxd_ring_engine_tb_top.sv
module rxd_ring_engine_tb_top;
  localparam int MINF = 64;
  localparam int MAXF = 100;

  logic clk = 0, rst_n = 0, poll = 0;
  logic [31:0] ring_base = '0;
  logic rx_valid = 0, rx_last = 0, rx_crc_bad = 0, rx_align_bad = 0, rx_fifo_ovf = 0, rx_sys_err = 0;
  logic [7:0] rx_data = '0;
  logic [1:0] rx_kind = '0;
  logic rx_ready, mem_rd, mem_wr, rx_done, no_buf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  always #10 clk = ~clk;

  rxd_ring_engine #(.AW(32), .MIN_FRAME(MINF), .MAX_FRAME(MAXF)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll(poll), .ring_base(ring_base),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_bad(rx_crc_bad), .rx_align_bad(rx_align_bad), .rx_fifo_ovf(rx_fifo_ovf),
    .rx_sys_err(rx_sys_err), .rx_kind(rx_kind), .rx_ready(rx_ready),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .rx_done(rx_done), .no_buf(no_buf));

  logic [31:0] mem [0:1023];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  int checks = 0, errors = 0, ndone = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int f, int i);
    return 8'(f * 37 + i);
  endfunction

  function automatic logic [7:0] rbyte(logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] exp_sts(int n, int bsz, bit crc, bit aln, bit ovf, bit sys, logic [1:0] k);
    logic [31:0] s;
    bit tr, sm;
    tr = n > bsz;
    sm = tr | sys | ovf | aln | crc;
    s = (32'(n) << 16) | 32'h300;
    if (!sm) s |= 32'h8000;
    if (k == 2'd1) s |= 32'h0800;
    if (k == 2'd2) s |= 32'h1000;
    if (k == 2'd3) s |= 32'h2000;
    if (tr)  s |= 32'h80;
    if (sys) s |= 32'h40;
    if (n < MINF) s |= 32'h20;
    if (n > MAXF) s |= 32'h10;
    if (ovf) s |= 32'h08;
    if (aln) s |= 32'h04;
    if (crc) s |= 32'h02;
    if (sm)  s |= 32'h01;
    return s;
  endfunction

  typedef struct {
    bit nobuf;
    logic [31:0] addr;
    logic [31:0] sts;
    logic [31:0] lb_addr;
    logic [7:0]  lb_val;
    bit          has_sent;
    logic [31:0] sent_addr;
  } exp_t;
  exp_t q[$];

  task automatic push_frame(logic [31:0] d, logic [31:0] bufa, int bsz, int f, int n,
                            bit crc, bit aln, bit ovf, bit sys, logic [1:0] k);
    exp_t e;
    int last;
    last = (n < bsz ? n : bsz) - 1;
    e.nobuf = 0; e.addr = d; e.sts = exp_sts(n, bsz, crc, aln, ovf, sys, k);
    e.lb_addr = bufa + 32'(last); e.lb_val = pat(f, last);
    e.has_sent = n > bsz; e.sent_addr = bufa + 32'(bsz);
    q.push_back(e);
  endtask

  task automatic push_nobuf();
    exp_t e;
    e.nobuf = 1; e.addr = '0; e.sts = '0; e.lb_addr = '0; e.lb_val = '0;
    e.has_sent = 0; e.sent_addr = '0;
    q.push_back(e);
  endtask

  bit pend_done = 0, pend_val = 0;
  always @(negedge clk) if (rst_n && !finished) begin
    exp_t e;
    if (rx_done) ndone++;
    if (pend_done) begin
      chk(rx_done == pend_val, "R10 done strobe", 32'(rx_done), 32'(pend_val));
      pend_done = 0;
    end
    if (mem_wr && mem_addr < 32'h400 && mem_be == 4'hf) begin
      if (q.size() == 0) chk(0, "R5 unexpected status write", mem_addr, 0);
      else begin
        e = q.pop_front();
        chk(!e.nobuf && mem_addr == e.addr, "R11 status descriptor address", mem_addr, e.addr);
        chk(mem_wdata == e.sts, "R5 R6 R7 R8 status word", mem_wdata, e.sts);
        chk(rbyte(e.lb_addr) == e.lb_val, "R9 data before status", 32'(rbyte(e.lb_addr)), 32'(e.lb_val));
        if (e.has_sent)
          chk(rbyte(e.sent_addr) == 8'hEE, "R4 byte past buffer untouched", 32'(rbyte(e.sent_addr)), 32'hEE);
        pend_done = 1;
        pend_val = e.sts[15];
      end
    end
    if (no_buf) begin
      if (q.size() == 0) chk(0, "R2 unexpected no_buf", 1, 0);
      else begin
        e = q.pop_front();
        chk(e.nobuf, "R2 no_buf when expected", 1, 32'(e.nobuf));
      end
    end
  end

  task automatic set_desc(logic [31:0] a, bit own, int bsz, logic [31:0] bufa, logic [31:0] nxt);
    mem[a[11:2]]     = {own, 31'b0};
    mem[a[11:2] + 1] = 32'(bsz);
    mem[a[11:2] + 2] = bufa;
    mem[a[11:2] + 3] = nxt;
  endtask

  task automatic do_poll(logic [31:0] base, logic [31:0] first, string tag);
    @(negedge clk);
    ring_base = base; poll = 1;
    @(negedge clk);
    poll = 0;
    chk(mem_rd && mem_addr == first, tag, mem_addr, first);
  endtask

  task automatic send(int f, int n, bit crc, bit aln, bit ovf, bit sys, logic [1:0] k);
    for (int i = 0; i < n; i++) begin
      while (!rx_ready) @(negedge clk);
      rx_valid = 1; rx_data = pat(f, i); rx_last = (i == n - 1);
      rx_crc_bad = crc; rx_align_bad = aln; rx_fifo_ovf = ovf; rx_sys_err = sys; rx_kind = k;
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_buf(logic [31:0] bufa, int n, int f, string tag);
    bit ok = 1;
    for (int i = 0; i < n; i++) if (rbyte(bufa + 32'(i)) != pat(f, i)) ok = 0;
    chk(ok, tag, 32'(ok), 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rx_ready && !mem_rd && !mem_wr && !rx_done && !no_buf, "R1 reset outputs",
        {27'b0, rx_ready, mem_rd, mem_wr, rx_done, no_buf}, 0);
    rst_n = 1;
    set_desc(32'h00, 1, 256, 32'h400, 32'h10);
    set_desc(32'h10, 1, 256, 32'h500, 32'h20);
    set_desc(32'h20, 1, 40,  32'h600, 32'h30);
    set_desc(32'h30, 1, 256, 32'h700, 32'h00);
    repeat (2) @(negedge clk);
    chk(!rx_ready, "R1 idle without poll", 32'(rx_ready), 0);
    do_poll(32'h00, 32'h00, "R1 first fetch at ring_base");
    push_frame(32'h00, 32'h400, 256, 1, 64, 0, 0, 0, 0, 2'd1);
    send(1, 64, 0, 0, 0, 0, 2'd1);
    push_frame(32'h10, 32'h500, 256, 2, 30, 1, 0, 0, 0, 2'd2);
    send(2, 30, 1, 0, 0, 0, 2'd2);
    push_frame(32'h20, 32'h600, 40, 3, 70, 0, 0, 0, 0, 2'd3);
    send(3, 70, 0, 0, 0, 0, 2'd3);
    push_frame(32'h30, 32'h700, 256, 4, 67, 0, 0, 1, 0, 2'd0);
    send(4, 67, 0, 0, 1, 0, 2'd0);
    drain();
    check_buf(32'h400, 64, 1, "R3 buffer contents frame 1");
    check_buf(32'h700, 67, 4, "R3 buffer contents odd length");
    check_buf(32'h600, 40, 3, "R4 truncated buffer prefix");
    chk(!rx_ready && !mem_rd, "R11 stopped at null next", {30'b0, rx_ready, mem_rd}, 0);

    set_desc(32'h40, 1, 200, 32'h800, 32'h50);
    set_desc(32'h50, 0, 256, 32'h900, 32'h00);
    do_poll(32'h40, 32'h40, "R11 restart at ring_base after null");
    push_frame(32'h40, 32'h800, 200, 5, 120, 0, 1, 0, 1, 2'd1);
    push_nobuf();
    send(5, 120, 0, 1, 0, 1, 2'd1);
    drain();
    chk(!rx_ready && !mem_rd, "R2 stopped on unowned descriptor", {30'b0, rx_ready, mem_rd}, 0);
    chk(rbyte(32'h900) == 8'hEE, "R2 unowned buffer untouched", 32'(rbyte(32'h900)), 32'hEE);
    set_desc(32'h50, 1, 256, 32'h900, 32'h00);
    do_poll(32'h40, 32'h50, "R2 poll refetches same descriptor");
    push_frame(32'h50, 32'h900, 256, 6, 65, 0, 0, 0, 0, 2'd2);
    send(6, 65, 0, 0, 0, 0, 2'd2);
    drain();
    chk(ndone == 2, "R10 good frame count", 32'(ndone), 2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 act=%h exp=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule